// File: doc/BRIEF.md
# Four-Phase Clock Divider

This block turns a square-wave timing input into a square wave at half its rate. It also produces four phase signals at that same half rate, with their start points a quarter of their period apart. It is a synchronous model of a divider that was built from cross-coupled gates. A fast system clock samples the timing input. Both of the input's edges are detected, and each edge moves a two-bit step counter forward by one. All outputs are registered and decoded from that counter. Because one output period spans four input half-periods, the phases start in the order A, C, B, D, one input half-period apart.

The timing input is active-low and idles high. The circuit has no state it settles into by itself, so a synchronous reset forces it to a known step. There is no data stream through this block. Every pin is a plain control or clock-like level, so no valid/ready handshake applies. The system clock must be fast enough that each input half-period lasts at least five system clock cycles.

Top module: `quad_phase_divider`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs go to step 0 on the next cycle: `ph_a`=1, `ph_d`=1, `ph_b`=0, `ph_c`=0, `half_out`=0.
- R2: Every transition of `tick_n`, rising or falling, advances the step by exactly one, modulo 4. After k transitions since reset the outputs show step k mod 4.
- R3: `half_out` is high in steps 2 and 3 and low in steps 0 and 1. With a steady input half-period of H cycles it is high for 2H cycles and low for 2H cycles, so its period is two input periods.
- R4: Each phase output is high for two consecutive steps and low for the other two. With steady H, each phase has a high time of 2H, a low time of 2H and a period of 4H.
- R5: Phase rises happen in the order A (entering step 0), C (step 1), B (step 2), D (step 3), one input half-period apart. Exactly two of the four phases are high at all times.
- R6: The decode is: step 0 gives A and D high; step 1 gives A and C; step 2 gives C and B; step 3 gives B and D.
- R7: A transition of `tick_n` driven between clock edges changes the outputs on the fourth rising clock edge after it, and not before. While `tick_n` is held steady, no output changes.
- R8: The input synchroniser resets to the idle (high) level. If `tick_n` is low when reset is released, that counts as one transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the timing input |
| rst | input | 1 | Synchronous reset, active high |
| tick_n | input | 1 | Active-low square-wave timing input, asynchronous to `clk` |
| half_out | output | 1 | Square wave at half the rate of `tick_n` |
| ph_a | output | 1 | Phase A, first in the rise order |
| ph_b | output | 1 | Phase B, third in the rise order |
| ph_c | output | 1 | Phase C, second in the rise order |
| ph_d | output | 1 | Phase D, fourth in the rise order |

## Verification
The bench targets three things. First, a falling input edge must count the same as a rising one. A detector that sees only one edge would give a quarter-rate output whose phases skip steps. Second, the rise order must be A, C, B, D. A decoder that follows the alphabet would put B directly after A, and the measured rise-to-rise spacings would then be 2H instead of H. Third, the latency must be exactly four edges, and an input left low at reset release must count as a transition. A synchroniser that reset to the wrong level, or had one flop too few or too many, would show up as a step offset of one or as output changes a cycle early or late.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int STEP_W = 2;
  localparam int NSTEPS = 1 << STEP_W;

  typedef logic [STEP_W-1:0] step_t;

  typedef struct packed {
    logic half;
    logic a;
    logic c;
    logic b;
    logic d;
  } taps_t;

  // Each phase is high for two adjacent steps; rises go A, C, B, D.
  function automatic taps_t taps_of(step_t s);
    taps_t t;
    t.half = s[1];
    t.a    = ~s[1];
    t.b    = s[1];
    t.c    = s[1] ^ s[0];
    t.d    = ~(s[1] ^ s[0]);
    return t;
  endfunction
endpackage

// File: rtl/qpd_edge_sync.sv
module qpd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  // pipe[0..STAGES-1] synchronise, pipe[STAGES] holds the previous settled level
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign edge_o = pipe[STAGES] ^ pipe[STAGES-1];

  // R7: a steady input yields no edge pulse once the pipe has flushed
  assert_quiet_input_R7: assert property (@(posedge clk) disable iff (rst)
    (pipe[STAGES-1:0] == {STAGES{pipe[STAGES]}}) |=> !edge_o || ($past(din) != pipe[STAGES]));
endmodule

// File: rtl/qpd_step_counter.sv
module qpd_step_counter
  import qpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  output step_t cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + step_t'(1);
  end

  assert_advance_one_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt == step_t'($past(cnt) + step_t'(1)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));
endmodule

// File: rtl/qpd_decode.sv
module qpd_decode
  import qpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_t cnt,
  output taps_t taps
);
  always_ff @(posedge clk) begin
    if (rst) taps <= taps_of('0);
    else     taps <= taps_of(cnt);
  end

  assert_two_high_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({taps.a, taps.b, taps.c, taps.d}) == 2);
  assert_one_swap_R4: assert property (@(posedge clk) disable iff (rst)
    ($countones({taps.a, taps.b, taps.c, taps.d} ^ $past({taps.a, taps.b, taps.c, taps.d})) == 0) ||
    ($countones({taps.a, taps.b, taps.c, taps.d} ^ $past({taps.a, taps.b, taps.c, taps.d})) == 2));
  assert_half_follows_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(taps.half) |-> $rose(taps.b) && $fell(taps.a));
endmodule

// File: rtl/quad_phase_divider.sv
module quad_phase_divider
  import qpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_n,
  output logic half_out,
  output logic ph_a,
  output logic ph_b,
  output logic ph_c,
  output logic ph_d
);
  logic  edge_seen;
  step_t step_q;
  taps_t taps_q;

  qpd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (tick_n),
    .edge_o (edge_seen)
  );

  qpd_step_counter u_cnt (
    .clk  (clk),
    .rst  (rst),
    .step (edge_seen),
    .cnt  (step_q)
  );

  qpd_decode u_dec (
    .clk  (clk),
    .rst  (rst),
    .cnt  (step_q),
    .taps (taps_q)
  );

  assign half_out = taps_q.half;
  assign ph_a     = taps_q.a;
  assign ph_b     = taps_q.b;
  assign ph_c     = taps_q.c;
  assign ph_d     = taps_q.d;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> ph_a && ph_d && !ph_b && !ph_c && !half_out);
  assert_a_then_c_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_c) |-> ph_a && !ph_d);
endmodule

// File: tb/quad_phase_divider_bench.sv
`timescale 1ns/1ps
module quad_phase_divider_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_n = 1'b1;
  logic half_out, ph_a, ph_b, ph_c, ph_d;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int cyc = 0;
  bit done = 1'b0;

  int a_rise = 0, a_fall = 0, a_prev_rise = 0, a_hi = 0, a_lo = 0, a_per = 0;
  int h_rise = 0, h_fall = 0, h_hi = 0, h_lo = 0;
  int b_rise = 0, c_rise = 0, d_rise = 0;
  logic pa = 1'b1, pb = 1'b0, pc = 1'b0, pd = 1'b1, ph = 1'b0;

  always #10 clk = ~clk;

  quad_phase_divider u_quad_phase_divider (
    .clk(clk), .rst(rst), .tick_n(tick_n),
    .half_out(half_out), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .ph_d(ph_d)
  );

  // expected {half,a,b,c,d} after n transitions
  function automatic logic [4:0] expect_of(int n);
    int s = n % 4;
    return {logic'(s >= 2), logic'(s < 2), logic'(s >= 2),
            logic'(s == 1 || s == 2), logic'(s == 3 || s == 0)};
  endfunction

  task automatic check_state(int n, string tag);
    logic [4:0] got = {half_out, ph_a, ph_b, ph_c, ph_d};
    logic [4:0] exp = expect_of(n);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {half,a,b,c,d} actual=%b expected=%b (k=%0d)", tag, got, exp, n);
    end
  endtask

  task automatic check_int(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic toggle_wait(int h);
    tick_n = ~tick_n;
    k++;
    repeat (h) @(negedge clk);
  endtask

  // edge monitor for run lengths and rise spacing
  always @(negedge clk) begin
    cyc++;
    if (ph_a && !pa) begin a_lo = cyc - a_fall; a_per = cyc - a_prev_rise; a_prev_rise = cyc; a_rise = cyc; end
    if (!ph_a && pa) begin a_hi = cyc - a_rise; a_fall = cyc; end
    if (half_out && !ph) begin h_lo = cyc - h_fall; h_rise = cyc; end
    if (!half_out && ph) begin h_hi = cyc - h_rise; h_fall = cyc; end
    if (ph_b && !pb) b_rise = cyc;
    if (ph_c && !pc) c_rise = cyc;
    if (ph_d && !pd) d_rise = cyc;
    pa = ph_a; pb = ph_b; pc = ph_c; pd = ph_d; ph = half_out;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state(0, "R1 reset state");
    repeat (6) @(negedge clk);
    check_state(0, "R8 idle high input gives no step");

    // R7 latency: change only on fourth rising edge
    tick_n = 1'b0; k = 1;
    repeat (3) @(negedge clk);
    check_state(0, "R7 no change before fourth edge");
    @(negedge clk);
    check_state(1, "R7 change at fourth edge");
    repeat (4) @(negedge clk);

    // random half-periods, both edge polarities
    for (int i = 0; i < 40; i++) begin
      toggle_wait(5 + int'($urandom_range(9)));
      check_state(k, (tick_n ? "R2 rising transition step" : "R6 falling transition decode"));
    end

    // hold steady: nothing moves
    for (int i = 0; i < 6; i++) begin
      repeat (10) @(negedge clk);
      check_state(k, "R7 steady input holds outputs");
    end

    // directed steady H=8 for 16 input cycles, ending in step 3
    for (int i = 0; i < 32; i++) toggle_wait(8);
    while (k % 4 != 3) toggle_wait(8);
    check_state(k, "R6 decode at step 3");
    check_int(a_hi, 16, "R4 phase A high time");
    check_int(a_lo, 16, "R4 phase A low time");
    check_int(a_per, 32, "R4 phase A period");
    check_int(h_hi, 16, "R3 half_out high time");
    check_int(h_lo, 16, "R3 half_out low time");
    check_int(c_rise - a_rise, 8, "R5 C rises one half-period after A");
    check_int(b_rise - c_rise, 8, "R5 B rises one half-period after C");
    check_int(d_rise - b_rise, 8, "R5 D rises one half-period after B");

    // reset with input low: counts as one transition on release
    @(negedge clk);
    rst = 1'b1; tick_n = 1'b0;
    repeat (3) @(negedge clk);
    check_state(0, "R1 reset overrides running state");
    rst = 1'b0; k = 1;
    repeat (8) @(negedge clk);
    check_state(k, "R8 low input at release counts once");
    toggle_wait(8);
    check_state(k, "R2 rising after low release");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule